// File: doc/BRIEF.md
# Lock-Gated Startup Sequencer

This block runs the last phase of bringing a configurable device out of configuration. That phase is a fixed run of six startup cycles. When the run finishes, the device enters user mode.

A start request launches the run. An optional wait point can stop the run at any one of the six cycles. The run then stays there until a lock indication from an on-chip clock manager goes high. Because of this, user mode cannot begin before the generated clocks are stable.

The lock input may come from another clock domain, so it passes through a two-flop synchronizer before the block uses it. User mode is sticky: once reached, it holds until reset.

The wait enable and the wait-cycle selection are captured when a start request is accepted. They stay fixed for the rest of that run. The reported cycle index has three kinds of value:
- 0 to 5 while the run is in progress;
- 7 while idle;
- 6 in user mode.

Top module: `startup_lock_seq`

## Requirements
- R1: While reset is applied, and after reset until a start request is accepted, `step_idx` reads 7 and `in_user` reads 0.
- R2: A `go` pulse sampled while idle makes `step_idx` read 0 after that clock edge. `hold_en` and `hold_at` are captured at that edge, and later changes to them have no effect on the run in progress.
- R3: With no wait point, `step_idx` advances by one per clock, 0 through 5. On the edge after index 5, `in_user` rises and `step_idx` reads 6.
- R4: With `hold_en`=1 and `hold_at` in 0..5, `step_idx` stops at the value of `hold_at` for as long as the synchronized lock is low, and `in_user` stays 0.
- R5: `lock_raw` reaches the sequencer through two flops. After `lock_raw` rises between two edges, the index stays at the wait point across the next two edges. It moves on at the third edge, to the next index, or to 6 with `in_user`=1 when the wait point is 5.
- R6: A `hold_at` value of 6 or 7 means no wait point: the run completes in six cycles even with lock low.
- R7: Once `in_user` is 1 it stays 1, and `step_idx` stays 6, until reset, even if `lock_raw` falls.
- R8: `go` has no effect during a run or in user mode: the index keeps its own progression and is never restarted at 0.
- R9: If the synchronized lock is already high when the run reaches the wait point, the run does not stall there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Startup clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| go | input | 1 | Start request, sampled on the rising edge |
| hold_en | input | 1 | Enables waiting for lock at the selected cycle |
| hold_at | input | 3 | Cycle at which to wait (0..5; 6 and 7 mean none) |
| lock_raw | input | 1 | Lock indication from the clock manager, asynchronous |
| step_idx | output | 3 | Current startup cycle; 7 = idle, 6 = user mode |
| in_user | output | 1 | User-mode flag, sticky until reset |

## Verification
The bench puts the wait point at the first cycle, at a middle cycle and at the last cycle. At the last cycle, a design that tests lock only when advancing between indices would enter user mode without waiting.

The bench raises lock at a known time and counts the stall edges exactly. A design with one synchronizer flop too few or too many would resume one edge early or late.

Selections 6 and 7 must finish unstalled; a design that compared only the low bits, or left the wait point unbounded, would hang. The bench also changes the configuration in the middle of a run, pulses start in the middle of a run, and drops lock after user mode. These catch a design that samples the configuration live, one that restarts at index 0, and one whose user flag is not sticky.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_USER = 2'd2
  } sseq_state_e;
endpackage

// File: rtl/sseq_sync.sv
module sseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= {ff_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/sseq_ctrl.sv
module sseq_ctrl
  import sseq_pkg::*;
#(
  parameter int NUM_CYCLES = 6,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             hold_en,
  input  logic [IDX_W-1:0] hold_at,
  input  logic             lock_s,
  output logic [IDX_W-1:0] step_idx,
  output logic             in_user
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_CYCLES - 1);
  localparam logic [IDX_W-1:0] USER_CODE = IDX_W'(NUM_CYCLES);
  localparam logic [IDX_W-1:0] IDLE_CODE = '1;

  sseq_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             arm_q, arm_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic             cap_en;
  logic             stall;

  assign stall = arm_q && (idx_q == sel_q) && !lock_s;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cap_en  = 1'b0;
    arm_d   = hold_en && (32'(hold_at) < NUM_CYCLES);
    sel_d   = hold_at;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d = ST_RUN;
          idx_d   = '0;
          cap_en  = 1'b1;
        end
      end
      ST_RUN: begin
        if (!stall) begin
          if (idx_q == LAST_IDX) state_d = ST_USER;
          else                   idx_d   = idx_q + 1'b1;
        end
      end
      default: state_d = ST_USER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      arm_q   <= 1'b0;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (cap_en) begin
        arm_q <= arm_d;
        sel_q <= sel_d;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE: step_idx = IDLE_CODE;
      ST_RUN:  step_idx = idx_q;
      default: step_idx = USER_CODE;
    endcase
  end
  assign in_user = (state_q == ST_USER);

  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && go) |=> (step_idx == '0 && !in_user));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && idx_q != LAST_IDX && !(arm_q && idx_q == sel_q))
      |=> (step_idx == $past(step_idx) + 1'b1));

  a_r3_enter_user: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_user) |-> ($past(step_idx) == LAST_IDX));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && arm_q && idx_q == sel_q && !lock_s)
      |=> ($stable(step_idx) && !in_user));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    in_user |=> (in_user && step_idx == USER_CODE));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_IDLE));
endmodule

// File: rtl/startup_lock_seq.sv
module startup_lock_seq #(
  parameter int NUM_CYCLES  = 6,
  parameter int IDX_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             hold_en,
  input  logic [IDX_W-1:0] hold_at,
  input  logic             lock_raw,
  output logic [IDX_W-1:0] step_idx,
  output logic             in_user
);
  logic rst_sync_n;
  logic lock_s;

  sseq_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  sseq_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (lock_raw),
    .q     (lock_s)
  );

  sseq_ctrl #(.NUM_CYCLES(NUM_CYCLES), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .go       (go),
    .hold_en  (hold_en),
    .hold_at  (hold_at),
    .lock_s   (lock_s),
    .step_idx (step_idx),
    .in_user  (in_user)
  );
endmodule

// File: tb/startup_lock_seq_test.sv
`timescale 1ns/1ps
module startup_lock_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0;
  logic       hold_en = 1'b0;
  logic [2:0] hold_at = 3'd0;
  logic       lock_raw = 1'b0;
  logic [2:0] step_idx;
  logic       in_user;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  startup_lock_seq uut (
    .clk(clk), .rst_n(rst_n), .go(go), .hold_en(hold_en),
    .hold_at(hold_at), .lock_raw(lock_raw),
    .step_idx(step_idx), .in_user(in_user)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    go = 1'b0;
    step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic do_start();
    go = 1'b1;
    step();
    go = 1'b0;
  endtask

  task automatic expect_full_run(string req);
    for (int k = 0; k < 6; k++) begin
      chk(req, step_idx, k);
      step();
    end
    chk(req, step_idx, 6);
    chk(req, in_user, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step();
    chk("R1 idx in reset", step_idx, 7);
    chk("R1 user in reset", in_user, 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 idle idx", step_idx, 7);
    chk("R1 idle user", in_user, 0);
  endtask

  task automatic t_nowait();
    hold_en = 1'b0; lock_raw = 1'b0;
    do_reset();
    do_start();
    expect_full_run("R3");
  endtask

  task automatic t_badsel(int sel);
    hold_en = 1'b1; hold_at = 3'(sel); lock_raw = 1'b0;
    do_reset();
    do_start();
    expect_full_run("R6");
  endtask

  task automatic t_wait(int sel);
    hold_en = 1'b1; hold_at = 3'(sel); lock_raw = 1'b0;
    do_reset();
    do_start();
    for (int k = 0; k < sel; k++) begin
      chk("R4 approach", step_idx, k);
      step();
    end
    for (int k = 0; k < 4; k++) begin
      chk("R4 hold idx", step_idx, sel);
      chk("R4 hold user", in_user, 0);
      step();
    end
    lock_raw = 1'b1;
    step();
    chk("R5 sync edge1", step_idx, sel);
    step();
    chk("R5 sync edge2", step_idx, sel);
    step();
    chk("R5 resume", step_idx, sel + 1);
    chk("R5 resume user", in_user, (sel == 5) ? 1 : 0);
  endtask

  task automatic t_lockhigh();
    lock_raw = 1'b1; hold_en = 1'b1; hold_at = 3'd3;
    do_reset();
    do_start();
    expect_full_run("R9");
  endtask

  task automatic t_capture();
    hold_en = 1'b1; hold_at = 3'd1; lock_raw = 1'b0;
    do_reset();
    do_start();
    hold_en = 1'b0; hold_at = 3'd7;
    chk("R2 start idx", step_idx, 0);
    step();
    for (int k = 0; k < 3; k++) begin
      chk("R2 captured hold", step_idx, 1);
      step();
    end
  endtask

  task automatic t_ignore_sticky();
    hold_en = 1'b0; lock_raw = 1'b1;
    do_reset();
    do_start();
    step();
    chk("R8 run idx", step_idx, 1);
    go = 1'b1;
    step();
    go = 1'b0;
    chk("R8 go mid-run", step_idx, 2);
    repeat (4) step();
    chk("R8 reach user", in_user, 1);
    go = 1'b1;
    step();
    go = 1'b0;
    step();
    chk("R8 go in user idx", step_idx, 6);
    chk("R8 go in user flag", in_user, 1);
    lock_raw = 1'b0;
    repeat (5) step();
    chk("R7 sticky flag", in_user, 1);
    chk("R7 sticky idx", step_idx, 6);
  endtask

  initial begin
    t_reset();
    t_nowait();
    t_badsel(6);
    t_badsel(7);
    t_wait(0);
    t_wait(2);
    t_wait(5);
    t_lockhigh();
    t_capture();
    t_ignore_sticky();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule